// File: doc/BRIEF.md
# Dual-Channel DMA Control Register File

This block holds the software-visible control and status words for a DMA engine with two channels. One channel serves a storage (SCSI) controller and the other serves a network controller. A host bus writes and reads eight 32-bit words. Writes to either channel's control word have side effects: a fixed version code is stamped into the top nibble, the interrupt line can be dropped, and a one-cycle reset pulse can be sent to the attached peripheral. On the storage control word, bit 6 is also handled in a toggling way.

The storage channel's bus address lives in word 1. A transfer-done strobe from the bus master adds the transfer length to that address and marks the channel's interrupt as pending. Explicit raise and clear inputs also set and clear the pending flag. On the network channel, every address that the peripheral presents is combined by bitwise OR with the base held in word 7 before it goes out to the bus. The bus master datapath, address translation and the peripherals sit outside this block.

Top module: `dual_dma_csr`

## Requirements
- R1: After a synchronous active-low reset, words 0 and 4 read 0xA0000000 and all other words read 0. Both interrupt outputs and both reset pulses are low.
- R2: The word index is byte address bits [4:2]. Address bits [1:0] and all bits above bit 4 are ignored.
- R3: A write to word 4 stores 0xA in bits [31:28] and the written bits [27:0]. A write to word 0 does the same, except for the bit 6 rule in R4.
- R4: When word 0 is written with bit 7 clear, the rule for bit 6 is as follows. If the written bit 6 is 1, it is stored as 0. If the whole written value is zero, bit 6 is stored as 1. When bit 7 is set, bit 6 is stored as written.
- R5: A control-word write with bit 7 (reset) set raises that channel's reset pulse for exactly the one cycle after the write. The other channel's pulse stays low.
- R6: A channel's interrupt output is high exactly while its control bit 0 (pending) and bit 4 (enable) are both set. A write that clears bit 4 drops the output from the next cycle on.
- R7: Any write to word 1 also sets bit 26 (address loaded) of word 0. The other bits of word 0 are left as they were.
- R8: A transfer-done strobe with length N adds N to word 1, modulo 2^32, and sets bit 0 of word 0.
- R9: The raise input sets bit 0 of word 0 and the clear input clears it. If both are asserted in the same cycle, raise wins.
- R10: If a bus write hits word 0 or word 1 in the same cycle as a hardware update to that word, the written value is stored and the hardware update is dropped.
- R11: The network bus address output equals the peripheral address input ORed with word 7. It responds combinationally.
- R12: A read returns the addressed word one cycle later and changes no state. Between reads, the read data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_rd | input | 1 | Read strobe for one word |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sto_done | input | 1 | Storage transfer completed |
| sto_len | input | 24 | Length of the completed transfer |
| sto_raise | input | 1 | Set the storage pending flag |
| sto_clear | input | 1 | Clear the storage pending flag |
| sto_irq | output | 1 | Storage channel interrupt |
| sto_rst_pulse | output | 1 | Storage peripheral reset pulse |
| net_irq | output | 1 | Network channel interrupt |
| net_rst_pulse | output | 1 | Network peripheral reset pulse |
| net_addr_in | input | 32 | Address from the network peripheral |
| net_addr_out | output | 32 | Network address merged with the base |

## Verification
The control-word write path is tried with several patterns, and each one isolates a single branch of the bit 6 rule or of the nibble stamping:
- an all-zero value;
- a lone bit 6;
- bit 6 combined with the reset bit;
- values with arbitrary upper nibbles.

The address counter is driven with a length that stays in range and with a length that wraps past 2^32, which separates a true modulo add from a saturating or truncated one. Same-cycle collisions are covered by writes landing together with raise and done, and by raise landing together with clear; these pin down the priority order. Aliased addresses show that only index bits [4:2] are decoded.

// File: rtl/dual_dma_csr_pkg.sv
// Shared constants and the control-word write fold for the DMA register file.
// Assumes 32-bit words and eight registers.
package dual_dma_csr_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 8;
    localparam logic [3:0] VERSION_NIB = 4'hA;
    localparam int B_PEND  = 0;
    localparam int B_ENA   = 4;
    localparam int B_TOG   = 6;
    localparam int B_RST   = 7;
    localparam int B_DIR   = 8;
    localparam int B_LOAD  = 26;
    localparam int IDX_CTL_STO = 0;
    localparam int IDX_ADDR_STO = 1;
    localparam int IDX_CTL_NET = 4;
    localparam int IDX_NET_BASE = 7;

    // Value actually stored when software writes a control word.
    function automatic logic [WORD_W-1:0] fold_ctl(input logic [WORD_W-1:0] d,
                                                   input logic toggle_rule);
        logic [WORD_W-1:0] v;
        v = d;
        if (toggle_rule && !d[B_RST]) begin
            if (d[B_TOG])
                v[B_TOG] = 1'b0;
            else if (d == '0)
                v[B_TOG] = 1'b1;
        end
        v[WORD_W-1:WORD_W-4] = VERSION_NIB;
        return v;
    endfunction
endpackage

// File: rtl/dma_ctl_word.sv
// One channel's control word: software write fold, hardware pending set/clear,
// loaded flag, interrupt output and reset pulse.
// Assumes software writes take priority over every hardware update.
module dma_ctl_word
    import dual_dma_csr_pkg::*;
#(
    parameter bit TOGGLE_RULE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              hw_set,
    input  logic              hw_clr,
    input  logic              set_loaded,
    output logic [WORD_W-1:0] word,
    output logic              irq,
    output logic              rst_pulse
);
    // Control word update: write, then raise, then clear, then loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= {VERSION_NIB, {(WORD_W-4){1'b0}}};
        end else if (wr) begin
            word <= fold_ctl(wdata, TOGGLE_RULE);
        end else begin
            if (hw_set)
                word[B_PEND] <= 1'b1;
            else if (hw_clr)
                word[B_PEND] <= 1'b0;
            if (set_loaded)
                word[B_LOAD] <= 1'b1;
        end
    end

    // One-cycle reset pulse following a write with the reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_pulse <= 1'b0;
        else
            rst_pulse <= wr && wdata[B_RST];
    end

    // Interrupt is level: pending and enabled.
    assign irq = word[B_PEND] && word[B_ENA];

    // R5
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $past(wr && wdata[B_RST]));
    // R6
    ena_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[B_ENA]) |=> !irq);
    // R9
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && hw_set) |=> word[B_PEND]);
    // R7
    loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && set_loaded) |=> word[B_LOAD]);
    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (word[B_PEND] == $past(wdata[B_PEND])));
endmodule

// File: rtl/dma_addr_ctr.sv
// Storage channel address counter: software load or advance by transfer length.
// Assumes length is unsigned and the add wraps modulo 2^WORD_W.
module dma_addr_ctr
    import dual_dma_csr_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done,
    input  logic [LEN_W-1:0]  len,
    output logic [WORD_W-1:0] value
);
    localparam int PAD_W = WORD_W - LEN_W;

    // Address register: write beats advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr)
            value <= wdata;
        else if (done)
            value <= value + {{PAD_W{1'b0}}, len};
    end

    // R8
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && done) |=> (value == $past(value + {{PAD_W{1'b0}}, len})));
    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (value == $past(wdata)));
endmodule

// File: rtl/dual_dma_csr.sv
// Top of the dual-channel DMA register file: decodes word accesses, hosts the
// two control words, the storage address counter and plain storage words,
// and merges network addresses with the base word.
// Assumes at most one bus access per cycle and no wait states.
module dual_dma_csr
    import dual_dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              sto_done,
    input  logic [LEN_W-1:0]  sto_len,
    input  logic              sto_raise,
    input  logic              sto_clear,
    output logic              sto_irq,
    output logic              sto_rst_pulse,
    output logic              net_irq,
    output logic              net_rst_pulse,
    input  logic [WORD_W-1:0] net_addr_in,
    output logic [WORD_W-1:0] net_addr_out
);
    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [IDX_W-1:0]  idx;
    logic [NUM_WORDS-1:0] wr_hit;
    logic [WORD_W-1:0] words [NUM_WORDS];

    assign idx = bus_addr[IDX_W+1:2];

    // Decode of one-hot write strobes per word.
    always_comb begin
        wr_hit = '0;
        wr_hit[idx] = bus_wr;
    end

    dma_ctl_word #(.TOGGLE_RULE(1'b1)) u_ctl_sto (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_hit[IDX_CTL_STO]),
        .wdata      (bus_wdata),
        .hw_set     (sto_raise | sto_done),
        .hw_clr     (sto_clear),
        .set_loaded (wr_hit[IDX_ADDR_STO]),
        .word       (words[IDX_CTL_STO]),
        .irq        (sto_irq),
        .rst_pulse  (sto_rst_pulse)
    );

    dma_ctl_word #(.TOGGLE_RULE(1'b0)) u_ctl_net (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_hit[IDX_CTL_NET]),
        .wdata      (bus_wdata),
        .hw_set     (1'b0),
        .hw_clr     (1'b0),
        .set_loaded (1'b0),
        .word       (words[IDX_CTL_NET]),
        .irq        (net_irq),
        .rst_pulse  (net_rst_pulse)
    );

    dma_addr_ctr #(.LEN_W(LEN_W)) u_addr_sto (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_hit[IDX_ADDR_STO]),
        .wdata (bus_wdata),
        .done  (sto_done),
        .len   (sto_len),
        .value (words[IDX_ADDR_STO])
    );

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_plain
        if (g != IDX_CTL_STO && g != IDX_ADDR_STO && g != IDX_CTL_NET) begin : g_store
            logic [WORD_W-1:0] r;
            // Plain storage word with no side effects.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    r <= '0;
                else if (wr_hit[g])
                    r <= bus_wdata;
            end
            assign words[g] = r;
        end
    end

    // Registered read port, holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= words[idx];
    end

    assign net_addr_out = net_addr_in | words[IDX_NET_BASE];

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R5
    pulse_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sto_rst_pulse |-> !net_rst_pulse);
endmodule

// File: tb/dual_dma_csr_bench.sv
// Directed bench for the dual-channel DMA register file.
module dual_dma_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sto_done = 1'b0;
    logic [23:0] sto_len = '0;
    logic        sto_raise = 1'b0;
    logic        sto_clear = 1'b0;
    logic        sto_irq, sto_rst_pulse, net_irq, net_rst_pulse;
    logic [31:0] net_addr_in = '0;
    logic [31:0] net_addr_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dual_dma_csr u_dual_dma_csr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sto_done(sto_done), .sto_len(sto_len), .sto_raise(sto_raise),
        .sto_clear(sto_clear), .sto_irq(sto_irq), .sto_rst_pulse(sto_rst_pulse),
        .net_irq(net_irq), .net_rst_pulse(net_rst_pulse),
        .net_addr_in(net_addr_in), .net_addr_out(net_addr_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_raise();
        @(negedge clk); sto_raise = 1'b1;
        @(negedge clk); sto_raise = 1'b0;
    endtask

    task automatic pulse_done(input logic [23:0] n);
        @(negedge clk); sto_done = 1'b1; sto_len = n;
        @(negedge clk); sto_done = 1'b0;
    endtask

    // R1: reset values of every word and outputs.
    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1 sto_irq", {31'b0, sto_irq}, 32'h0);
        check("R1 net_irq", {31'b0, net_irq}, 32'h0);
        check("R1 pulses", {30'b0, sto_rst_pulse, net_rst_pulse}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd_reg(8'(i * 4), v);
            check($sformatf("R1 word%0d", i), v, (i == 0 || i == 4) ? 32'hA0000000 : 32'h0);
        end
    endtask

    // R2: aliasing through ignored address bits.
    task automatic t_decode();
        logic [31:0] v;
        do_reset();
        wr_reg(8'h1C, 32'h1234_5678);
        rd_reg(8'hFF, v);
        check("R2 alias read 0xFF", v, 32'h1234_5678);
        wr_reg(8'h2A, 32'h0BAD_F00D);
        rd_reg(8'h08, v);
        check("R2 alias write 0x2A", v, 32'h0BAD_F00D);
    endtask

    // R3/R4: control word folds.
    task automatic t_ctl_fold();
        logic [31:0] v;
        do_reset();
        wr_reg(8'h10, 32'h5123_4567);
        rd_reg(8'h10, v);
        check("R3 word4 nibble", v, 32'hA123_4567);
        wr_reg(8'h00, 32'h0000_0000);
        rd_reg(8'h00, v);
        check("R4 zero sets bit6", v, 32'hA000_0040);
        wr_reg(8'h00, 32'h0000_0040);
        rd_reg(8'h00, v);
        check("R4 bit6 cleared", v, 32'hA000_0000);
        wr_reg(8'h00, 32'hF000_00C0);
        rd_reg(8'h00, v);
        check("R4 bit6 kept with reset", v, 32'hA000_00C0);
        wr_reg(8'h00, 32'h3000_0100);
        rd_reg(8'h00, v);
        check("R3 word0 nibble", v, 32'hA000_0100);
    endtask

    // R5: reset pulse length and channel.
    task automatic t_rst_pulse();
        do_reset();
        wr_reg(8'h00, 32'h0000_0080);
        check("R5 sto pulse high", {31'b0, sto_rst_pulse}, 32'h1);
        check("R5 net pulse low", {31'b0, net_rst_pulse}, 32'h0);
        @(negedge clk);
        check("R5 sto pulse one cycle", {31'b0, sto_rst_pulse}, 32'h0);
        wr_reg(8'h10, 32'h0000_0080);
        check("R5 net pulse high", {31'b0, net_rst_pulse}, 32'h1);
        @(negedge clk);
        check("R5 net pulse one cycle", {31'b0, net_rst_pulse}, 32'h0);
    endtask

    // R6/R9: interrupt gating, raise and clear.
    task automatic t_irq();
        logic [31:0] v;
        do_reset();
        wr_reg(8'h00, 32'h0000_0010);
        check("R6 enable only", {31'b0, sto_irq}, 32'h0);
        pulse_raise();
        check("R9 raise drives irq", {31'b0, sto_irq}, 32'h1);
        wr_reg(8'h00, 32'h0000_0001);
        check("R6 disable drops irq", {31'b0, sto_irq}, 32'h0);
        wr_reg(8'h00, 32'h0000_0011);
        @(negedge clk); sto_clear = 1'b1;
        @(negedge clk); sto_clear = 1'b0;
        check("R9 clear drops irq", {31'b0, sto_irq}, 32'h0);
        @(negedge clk); sto_clear = 1'b1; sto_raise = 1'b1;
        @(negedge clk); sto_clear = 1'b0; sto_raise = 1'b0;
        check("R9 raise beats clear", {31'b0, sto_irq}, 32'h1);
        wr_reg(8'h10, 32'h0000_0011);
        check("R6 net irq on", {31'b0, net_irq}, 32'h1);
        wr_reg(8'h10, 32'h0000_0001);
        check("R6 net irq off", {31'b0, net_irq}, 32'h0);
        rd_reg(8'h00, v);
        check("R12 read no side effect", v, 32'hA000_0011);
        rd_reg(8'h00, v);
        check("R12 repeat read", v, 32'hA000_0011);
    endtask

    // R7/R8: loaded flag and address advance.
    task automatic t_addr();
        logic [31:0] v;
        do_reset();
        wr_reg(8'h00, 32'h0000_0010);
        wr_reg(8'h04, 32'h0000_1000);
        rd_reg(8'h00, v);
        check("R7 loaded flag", v, 32'hA400_0010);
        pulse_done(24'h20);
        rd_reg(8'h04, v);
        check("R8 advance", v, 32'h0000_1020);
        check("R8 irq from done", {31'b0, sto_irq}, 32'h1);
        rd_reg(8'h00, v);
        check("R8 pending set", v, 32'hA400_0011);
        wr_reg(8'h04, 32'hFFFF_FFF0);
        pulse_done(24'h20);
        rd_reg(8'h04, v);
        check("R8 wrap", v, 32'h0000_0010);
    endtask

    // R10: write beats hardware update in the same cycle.
    task automatic t_collide();
        logic [31:0] v;
        do_reset();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0000_0010; sto_raise = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; sto_raise = 1'b0;
        rd_reg(8'h00, v);
        check("R10 ctl write wins", v, 32'hA000_0010);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_0500;
        sto_done = 1'b1; sto_len = 24'h8;
        @(negedge clk);
        bus_wr = 1'b0; sto_done = 1'b0;
        rd_reg(8'h04, v);
        check("R10 addr write wins", v, 32'h0000_0500);
    endtask

    // R11/R12: network address merge and read hold.
    task automatic t_net_addr();
        logic [31:0] v;
        do_reset();
        wr_reg(8'h1C, 32'h8000_0000);
        net_addr_in = 32'h0000_1234;
        #1;
        check("R11 merge", net_addr_out, 32'h8000_1234);
        net_addr_in = 32'h8000_0001;
        #1;
        check("R11 overlap", net_addr_out, 32'h8000_0001);
        rd_reg(8'h1C, v);
        wr_reg(8'h1C, 32'h0000_0007);
        @(negedge clk);
        check("R12 rdata holds", bus_rdata, 32'h8000_0000);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_ctl_fold();
        t_rst_pulse();
        t_irq();
        t_addr();
        t_collide();
        t_net_addr();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule